// File: doc/BRIEF.md
# MDIO Management Command Controller

This block is a register-driven master for the two-wire PHY management bus. Software writes a 16-bit command word that names a PHY address, a register number and whether the access is a read or a write. The block then sends one complete 64-bit management frame on MDC/MDIO and controls the MDIO output enable for an external tri-state pad.

Write data comes from its own write-data register, which software loads before it issues the write command. Read data is captured from the PHY and goes into a separate read-data register. The request bit in the command register does two jobs. Writing it starts a transaction, and it reads back as 1 until the frame has finished, so software polls it to detect completion.

MDC is the system clock divided by a parameter. It stays low whenever no transaction is running.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset, the command readback is 0x0000, the read-data register is 0x0000, and `mdc_o` and `mdio_oe_o` are 0.
- R2: In the command word, bits 12:8 hold the 5-bit PHY address, bits 4:0 hold the 5-bit register number, bit 13 requests a read and bit 14 requests a write. When both request bits are set, a write is performed. The readback shows the stored PHY address and register number in the same positions, and shows the active request bit in its own position.
- R3: The request bit reads back as 1 from the clock after the accepted command. It clears by itself exactly 128*CLK_DIV system clocks after the accepting edge.
- R4: While a transaction runs, MDC has a period of 2*CLK_DIV system clocks. MDC stays low while idle.
- R5: Every frame is sent MSB first in this order: 32 ones, the start code 01, the opcode, the PHY address, the register number, a 2-bit turnaround, then 16 data bits. The opcode is 10 for a read and 01 for a write. MDIO changes only after a falling edge of MDC.
- R6: On a write, `mdio_oe_o` stays high for all 64 bits, the turnaround is driven as 10, and the data field is the write-data register.
- R7: On a read, `mdio_oe_o` is low for the last 18 bits, which are the turnaround and the data. `mdio_i` is sampled at each rising MDC edge of the data field. The read-data register keeps its previous value during the frame and takes the new 16-bit value when the request bit clears.
- R8: The write-data register is captured when the command is accepted. A load in the same cycle as the command, or a load during the frame, does not change the current frame. Such a load applies to the next write.
- R9: A command written while a transaction is busy is ignored. This includes a command in the clock edge on which the busy flag clears.
- R10: A command word with neither request bit set starts nothing and leaves the command readback unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_we_i | input | 1 | Write strobe for the command register |
| cmd_wdata_i | input | 16 | Command word |
| cmd_rdata_o | output | 16 | Command readback: fields and active request bit |
| wdat_we_i | input | 1 | Write strobe for the write-data register |
| wdat_i | input | 16 | Write-data value |
| rdat_o | output | 16 | Read-data register |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe_o | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input from the pad |

## Verification
The bench provokes two same-cycle collisions.

In the first, a new command is pulsed exactly on the clock edge where the last MDC fall ends the current frame. That edge is located by counting CLK_DIV clocks from the final MDC rise. The bench judges the outcome by three things: the readback fields are unchanged, no further MDC edges appear, and the completion time is still 128*CLK_DIV clocks.

In the second, a write-data load and a write command land in the same cycle. The captured frame must carry the older data, and the following write must carry the newly loaded value.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;
  localparam int DATA_W     = 16;
  localparam int ADDR_W     = 5;
  localparam int PRE_BITS   = 32;
  localparam int FRAME_BITS = PRE_BITS + 2 + 2 + 2*ADDR_W + 2 + DATA_W;
  localparam int TA_POS     = FRAME_BITS - DATA_W - 2;
  localparam int DATA_POS   = FRAME_BITS - DATA_W;
  localparam int IDX_W      = $clog2(FRAME_BITS);
  localparam int CMD_RD_BIT = 13;
  localparam int CMD_WR_BIT = 14;
  localparam int PHY_LSB    = 8;

  typedef enum logic [1:0] {
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10
  } mdio_op_e;
endpackage

// File: rtl/mdio_clk_div.sv
`timescale 1ns/1ps
module mdio_clk_div #(
  parameter int CLK_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic mdc_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CNT_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(CLK_DIV - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             mdc_q;
  logic             tick;

  assign tick   = run_i && (cnt_q == CNT_MAX);
  assign rise_o = tick && !mdc_q;
  assign fall_o = tick && mdc_q;
  assign mdc_o  = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R4: the divider holds MDC high for exactly CLK_DIV clocks
  assert_no_double_rise_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o)
    else $error("R4 MDC rise strobe repeated");
endmodule

// File: rtl/mdio_frame_seq.sv
`timescale 1ns/1ps
module mdio_frame_seq
  import mdio_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              is_write_i,
  input  logic [ADDR_W-1:0] phy_i,
  input  logic [ADDR_W-1:0] reg_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              mdio_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  output logic [DATA_W-1:0] rshift_o
);
  logic [FRAME_BITS-1:0] tx_q;
  logic [IDX_W-1:0]      idx_q;
  logic                  busy_q;
  logic                  wr_q;
  logic [DATA_W-1:0]     rsh_q;
  logic [FRAME_BITS-1:0] frame_d;
  mdio_op_e              op;
  logic                  last_bit;

  assign op       = is_write_i ? OP_WRITE : OP_READ;
  assign frame_d  = {{PRE_BITS{1'b1}}, 2'b01, op, phy_i, reg_i,
                     (is_write_i ? 2'b10 : 2'b11), wdata_i};
  assign last_bit = (idx_q == IDX_W'(FRAME_BITS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q   <= '0;
      idx_q  <= '0;
      busy_q <= 1'b0;
      wr_q   <= 1'b0;
      rsh_q  <= '0;
    end else if (start_i && !busy_q) begin
      tx_q   <= frame_d;
      idx_q  <= '0;
      busy_q <= 1'b1;
      wr_q   <= is_write_i;
    end else if (busy_q) begin
      if (rise_i && !wr_q && idx_q >= IDX_W'(DATA_POS))
        rsh_q <= {rsh_q[DATA_W-2:0], mdio_i};
      if (fall_i) begin
        if (last_bit) begin
          busy_q <= 1'b0;
        end else begin
          idx_q <= idx_q + 1'b1;
          tx_q  <= {tx_q[FRAME_BITS-2:0], 1'b0};
        end
      end
    end
  end

  assign busy_o    = busy_q;
  assign done_o    = busy_q && fall_i && last_bit;
  assign mdio_o    = busy_q ? tx_q[FRAME_BITS-1] : 1'b1;
  assign mdio_oe_o = busy_q && (wr_q || idx_q < IDX_W'(TA_POS));
  assign rshift_o  = rsh_q;

  // R5: bit position only advances on an MDC fall
  assert_idx_on_fall_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && $past(busy_q) && idx_q != $past(idx_q)) |-> $past(fall_i))
    else $error("R5 bit index moved without MDC fall");
  // R7: pad released for the whole read turnaround and data field
  assert_read_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !wr_q && idx_q >= IDX_W'(TA_POS)) |-> !mdio_oe_o)
    else $error("R7 MDIO driven during read data");
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
`timescale 1ns/1ps
module mdio_mgmt_ctrl
  import mdio_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cmd_we_i,
  input  logic [15:0] cmd_wdata_i,
  output logic [15:0] cmd_rdata_o,
  input  logic        wdat_we_i,
  input  logic [15:0] wdat_i,
  output logic [15:0] rdat_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        mdio_i
);
  logic [ADDR_W-1:0] phy_q, reg_q;
  logic              op_wr_q;
  logic [DATA_W-1:0] wdat_q, rdat_q, rshift;
  logic              busy, done, rise, fall, start, req_rd, req_wr;
  logic              unused_cmd_bits;

  assign unused_cmd_bits = ^{cmd_wdata_i[15], cmd_wdata_i[7:5]};
  assign req_rd = cmd_wdata_i[CMD_RD_BIT];
  assign req_wr = cmd_wdata_i[CMD_WR_BIT];
  assign start  = cmd_we_i && !busy && (req_rd || req_wr);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phy_q   <= '0;
      reg_q   <= '0;
      op_wr_q <= 1'b0;
      wdat_q  <= '0;
      rdat_q  <= '0;
    end else begin
      if (start) begin
        phy_q   <= cmd_wdata_i[PHY_LSB +: ADDR_W];
        reg_q   <= cmd_wdata_i[ADDR_W-1:0];
        op_wr_q <= req_wr;
      end
      if (wdat_we_i) wdat_q <= wdat_i;
      if (done && !op_wr_q) rdat_q <= rshift;
    end
  end

  mdio_clk_div #(.CLK_DIV(CLK_DIV)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy),
    .mdc_o  (mdc_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  mdio_frame_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .is_write_i (req_wr),
    .phy_i      (cmd_wdata_i[PHY_LSB +: ADDR_W]),
    .reg_i      (cmd_wdata_i[ADDR_W-1:0]),
    .wdata_i    (wdat_q),
    .rise_i     (rise),
    .fall_i     (fall),
    .mdio_i     (mdio_i),
    .busy_o     (busy),
    .done_o     (done),
    .mdio_o     (mdio_o),
    .mdio_oe_o  (mdio_oe_o),
    .rshift_o   (rshift)
  );

  assign cmd_rdata_o = {1'b0, busy && op_wr_q, busy && !op_wr_q, phy_q, 3'b000, reg_q};
  assign rdat_o      = rdat_q;

  assert_idle_mdc_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> !mdc_o)
    else $error("R4 MDC toggling while idle");
  assert_mdio_hold_high_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mdc_o && $past(mdc_o)) |-> $stable(mdio_o))
    else $error("R5 MDIO changed while MDC high");
  assert_start_from_cmd_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(cmd_we_i && (cmd_wdata_i[CMD_RD_BIT] || cmd_wdata_i[CMD_WR_BIT])))
    else $error("R9 transaction began without a request");
  assert_fields_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && $past(busy)) |-> $stable(cmd_rdata_o))
    else $error("R9 command changed while busy");
  assert_rdat_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && $past(busy)) |-> $stable(rdat_o))
    else $error("R7 read data changed mid-frame");
endmodule

// File: tb/mdio_mgmt_ctrl_tb.sv
`timescale 1ns/1ps
module mdio_mgmt_ctrl_tb;
  localparam int DIV = 2;
  localparam int TCK = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_we = 1'b0;
  logic [15:0] cmd_wd = '0;
  logic [15:0] cmd_rd;
  logic        wdat_we = 1'b0;
  logic [15:0] wdat = '0;
  logic [15:0] rdat;
  logic        mdc, mdio_out, mdio_oe;
  logic        mdio_in = 1'b1;

  int checks = 0;
  int fails  = 0;
  int mdc_rises = 0;
  logic [15:0] last_rdat = '0;

  always #(TCK/2) clk = ~clk;
  always @(posedge mdc) mdc_rises++;

  mdio_mgmt_ctrl #(.CLK_DIV(DIV)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_we_i(cmd_we), .cmd_wdata_i(cmd_wd), .cmd_rdata_o(cmd_rd),
    .wdat_we_i(wdat_we), .wdat_i(wdat), .rdat_o(rdat),
    .mdc_o(mdc), .mdio_o(mdio_out), .mdio_oe_o(mdio_oe), .mdio_i(mdio_in)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load_wdat(input logic [15:0] v);
    @(negedge clk); wdat_we = 1'b1; wdat = v;
    @(negedge clk); wdat_we = 1'b0;
  endtask

  // cmd: full command word; pd: PHY data on reads; wexp: expected write data in frame
  // same_wd: load same_val in the command cycle; poke: command mid-frame; collide: command on the ending edge
  task automatic txn(input logic [15:0] cmd, input logic [15:0] pd, input logic [15:0] wexp,
                     input bit same_wd, input logic [15:0] same_val,
                     input bit poke, input bit collide);
    logic        wr;
    logic [4:0]  phy, rg;
    logic [63:0] got, got_oe, exp, exp_oe, mask;
    logic [15:0] exp_rb;
    time         t0, t_done, tr [0:1];
    wr  = cmd[14];
    phy = cmd[12:8];
    rg  = cmd[4:0];
    mdio_in = 1'b1;
    @(negedge clk);
    cmd_we = 1'b1; cmd_wd = cmd;
    if (same_wd) begin wdat_we = 1'b1; wdat = same_val; end
    @(posedge clk); t0 = $time;
    @(negedge clk);
    cmd_we = 1'b0; wdat_we = 1'b0;
    exp_rb = {1'b0, wr, ~wr, phy, 3'b000, rg};
    chk(cmd_rd == exp_rb, "R2/R3 busy readback", 64'(cmd_rd), 64'(exp_rb));
    for (int k = 0; k < 64; k++) begin
      @(posedge mdc); #1;
      if (k < 2) tr[k] = $time;
      got[63-k]    = mdio_out;
      got_oe[63-k] = mdio_oe;
      if (k == 20 && poke) begin
        @(negedge clk); cmd_we = 1'b1; cmd_wd = 16'h2000 | 16'h1F1F;
        @(negedge clk); cmd_we = 1'b0;
      end
      if (k == 50 && !wr)
        chk(rdat == last_rdat, "R7 read data held mid-frame", 64'(rdat), 64'(last_rdat));
      if (k == 63 && collide) begin
        for (int j = 0; j < DIV; j++) @(negedge clk);
        cmd_we = 1'b1; cmd_wd = 16'h4000 | 16'h0A0A;
        @(posedge clk); t_done = $time;
        #1; cmd_we = 1'b0;
      end else begin
        @(negedge mdc); t_done = $time; #1;
        if (k < 63 && !wr) mdio_in = (k + 1 >= 48) ? pd[63-(k+1)] : 1'b1;
      end
    end
    chk(tr[1] - tr[0] == time'(2*DIV*TCK), "R4 MDC period", 64'(tr[1]-tr[0]), 64'(2*DIV*TCK));
    chk(t_done - t0 == time'(128*DIV*TCK), "R3 completion time", 64'(t_done-t0), 64'(128*DIV*TCK));
    @(negedge clk);
    exp_rb = {3'b000, phy, 3'b000, rg};
    chk(cmd_rd == exp_rb, "R3/R9 request cleared, fields kept", 64'(cmd_rd), 64'(exp_rb));
    exp    = {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), phy, rg, (wr ? 2'b10 : 2'b00), (wr ? wexp : 16'h0)};
    mask   = wr ? {64{1'b1}} : {{46{1'b1}}, 18'b0};
    exp_oe = mask;
    chk(((got ^ exp) & mask) == 0, wr ? "R5/R6 write frame bits" : "R5 read frame bits", got & mask, exp);
    chk(got_oe == exp_oe, wr ? "R6 write output enable" : "R7 read output enable", got_oe, exp_oe);
    if (!wr) begin
      chk(rdat == pd, "R7 read data captured", 64'(rdat), 64'(pd));
      last_rdat = pd;
    end else begin
      chk(rdat == last_rdat, "R6 write leaves read data", 64'(rdat), 64'(last_rdat));
    end
    if (collide || poke) begin
      int r0;
      r0 = mdc_rises;
      repeat (20) @(negedge clk);
      chk(mdc_rises == r0 && cmd_rd == exp_rb, "R9 ignored command left no trace",
          64'(mdc_rises - r0), 64'(0));
    end
  endtask

  initial begin
    #(200000*TCK);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cmd_rd == 16'h0 && rdat == 16'h0 && !mdc && !mdio_oe, "R1 reset state",
        {cmd_rd, rdat, 30'b0, mdc, mdio_oe}, 64'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!mdc && !mdio_oe, "R4 idle MDC low after reset", {62'b0, mdc, mdio_oe}, 64'h0);

    // read sweep over address/register corners and data patterns
    for (int i = 0; i < 6; i++) begin
      logic [4:0]  p, r;
      logic [15:0] d;
      p = 5'((i * 13 + 1) % 32);
      r = 5'((i * 7 + 31) % 32);
      d = 16'hA5C3 ^ 16'(i * 16'h1111);
      if (i == 5) d = 16'hFFFF;
      if (i == 4) d = 16'h0001;
      txn(16'h2000 | {3'b000, p, 3'b000, r}, d, 16'h0, 1'b0, 16'h0, 1'b0, 1'b0);
    end

    // write sweep
    for (int i = 0; i < 4; i++) begin
      logic [15:0] w;
      w = 16'h8001 ^ 16'(i * 16'h2D4B);
      load_wdat(w);
      txn(16'h4000 | {3'b000, 5'(31 - i * 9), 3'b000, 5'(i * 10)}, 16'h0, w, 1'b0, 16'h0, 1'b0, 1'b0);
    end

    // R2: both request bits -> write
    load_wdat(16'h3C3C);
    txn(16'h6000 | 16'h1105, 16'h0, 16'h3C3C, 1'b0, 16'h0, 1'b0, 1'b0);

    // R8: load in the same cycle as the command uses the older value, next write uses the new one
    txn(16'h4000 | 16'h0203, 16'h0, 16'h3C3C, 1'b1, 16'h9999, 1'b0, 1'b0);
    txn(16'h4000 | 16'h0203, 16'h0, 16'h9999, 1'b0, 16'h0, 1'b0, 1'b0);

    // R9: command mid-frame (read) and on the completing edge (write)
    txn(16'h2000 | 16'h0407, 16'h5A5A, 16'h0, 1'b0, 16'h0, 1'b1, 1'b0);
    load_wdat(16'h1234);
    txn(16'h4000 | 16'h0506, 16'h0, 16'h1234, 1'b0, 16'h0, 1'b0, 1'b1);

    // R10: no request bit -> nothing starts, readback unchanged
    begin
      int r0;
      logic [15:0] rb;
      rb = cmd_rd;
      r0 = mdc_rises;
      @(negedge clk); cmd_we = 1'b1; cmd_wd = 16'h1F1F;
      @(negedge clk); cmd_we = 1'b0;
      repeat (3*DIV) @(negedge clk);
      chk(cmd_rd == rb && mdc_rises == r0 && !mdio_oe, "R10 empty command ignored",
          64'(cmd_rd), 64'(rb));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule